// File: doc/BRIEF.md
# Receive Packet Framer with Address Filter

This block sits behind a radio demodulator and clock recovery stage. It takes a serial bit stream, one bit for each strobe, looks for a programmable start pattern of one to four bytes, and then cuts the bits that follow into bytes. Preamble and start-pattern bits never leave the block. The bytes after the pattern go out on a byte-wide write port that feeds an external receive FIFO.

A packet is an optional node-address byte, then an optional length byte, then the payload, then a 16-bit check word. The address byte is compared against the node address in one of three filter modes, and a packet that fails is abandoned at once. A CRC runs over the address, length and payload bytes. A good packet raises a one-cycle OK pulse. A bad one raises an error pulse and, depending on configuration, its bytes are either passed through or held back and thrown away. A separate pulse marks start-pattern detection when address filtering is off, and an address match when it is on.

Bit strobes are assumed to be at least two clock cycles apart. The configuration is assumed to stay static while a packet is in flight. A fixed payload length must not exceed `MAX_LEN`.

Top module: `rxpkt_framer`

## Requirements
- R1: The start pattern is the low `cfg_sync_sel+1` bytes of `cfg_sync_word`, sent most significant bit first. It is detected only as an exact match of that many most recent bits on a sliding window, and only once at least that many bits have arrived while searching. Noise or a pattern with one wrong bit produces no output byte and no pulse.
- R2: Bits before the pattern and the pattern itself are never output. The first output byte is the first byte after the pattern, assembled most significant bit first.
- R3: Field order after the pattern is address byte (if `cfg_addr_en`), length byte (if `cfg_len_en`), payload, check word with its high byte first. The length byte gives the payload byte count. With `cfg_len_en` low, the count is `cfg_fixed_len`. A count of zero goes straight to the check word.
- R4: Filter modes on `cfg_addr_mode`: 2'b00 accepts only `cfg_node_addr`; 2'b01 also accepts 0x00; 2'b10 and 2'b11 also accept 0x00 and 0xFF.
- R5: A packet whose address byte fails the filter produces no output byte and no pulse, and the framer resumes searching for the pattern.
- R6: `hit_pulse` is one cycle wide. It fires on pattern detection when `cfg_addr_en` is low, and on an accepted address byte (not on the pattern) when `cfg_addr_en` is high.
- R7: The CRC uses polynomial 0x1021 with a 0xFFFF preset, processing bytes most significant bit first over address, length and payload. A match fires one `crc_ok` pulse; a mismatch fires one `crc_err` pulse. The two never fire together.
- R8: With `cfg_discard` low, every byte of an address-accepted packet is output as it arrives, whether or not the CRC later fails.
- R9: With `cfg_discard` high, the bytes are held and released back to back only after a good CRC. A bad packet outputs nothing. A full packet of `MAX_LEN` payload bytes plus address and length fits.
- R10: A length byte above `MAX_LEN` drops the packet: no further bytes, no CRC pulse, and the search resumes.
- R11: After reset all outputs are low and the framer is searching for the pattern.
- R12: After a packet ends, the next packet is received without a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_valid | input | 1 | Strobe: one received bit on `bit_data` |
| bit_data | input | 1 | Received bit |
| cfg_sync_word | input | SYNC_BYTES*8 | Start pattern, low bytes used |
| cfg_sync_sel | input | SEL_W | Pattern length minus one, in bytes |
| cfg_addr_en | input | 1 | Address byte present and filtered |
| cfg_addr_mode | input | 2 | Address filter mode |
| cfg_node_addr | input | 8 | Own node address |
| cfg_len_en | input | 1 | Length byte present |
| cfg_fixed_len | input | 8 | Payload count when no length byte |
| cfg_discard | input | 1 | Hold and discard packets with a bad CRC |
| out_valid | output | 1 | Write strobe to the receive FIFO |
| out_data | output | 8 | Byte to write |
| hit_pulse | output | 1 | Pattern detected or address matched |
| crc_ok | output | 1 | Packet ended with a good CRC |
| crc_err | output | 1 | Packet ended with a bad CRC |

## Verification
A framer stuck in the wrong field state shows up at the ports within one byte time, which is eight bit strobes. It appears as an address or length byte missing from the output, a payload byte too many or too few before the CRC pulse, or a CRC verdict that flips because the check word was read from the wrong bytes. A search that resumes too late or too early shows up on the next packet as a missing `hit_pulse` or as stray bytes. A hold buffer that loses its count shows up in discard mode as a short or overlong burst of bytes after `crc_ok`, or as bytes leaking out before the verdict. Each packet is compared byte for byte and pulse for pulse against values built from the packet the bench sent.

// File: rtl/rxf_pkg.sv
// Shared types and the CRC step function for the receive framer.
// Assumes bytes are fed to the CRC most significant bit first.
package rxf_pkg;

    // Field-walking states of the framer control.
    typedef enum logic [2:0] {
        ST_HUNT,
        ST_ADDR,
        ST_LEN,
        ST_PAY,
        ST_CRC_HI,
        ST_CRC_LO,
        ST_DRAIN
    } rxf_state_e;

    localparam logic [15:0] CRC_POLY = 16'h1021;
    localparam logic [15:0] CRC_SEED = 16'hFFFF;

    // Advance a 16-bit CRC by one data byte, bit 7 first.
    function automatic logic [15:0] rxf_crc16_byte(input logic [15:0] c_in,
                                                   input logic [7:0]  d);
        logic [15:0] c;
        logic        fb;
        c = c_in;
        for (int i = 7; i >= 0; i--) begin
            fb = c[15] ^ d[i];
            c  = {c[14:0], 1'b0};
            if (fb) c = c ^ CRC_POLY;
        end
        return c;
    endfunction

endpackage

// File: rtl/rxf_sync_hunt.sv
// Start-pattern search over a sliding bit window.
// Does: shifts bits in while enabled and reports an exact match of the
// selected number of pattern bytes on the bit that completes it.
// Assumes: the pattern sits in the low bytes of sync_word, MSB sent first.
// The bit counter restarts whenever searching is disabled.
module rxf_sync_hunt #(
    parameter int SYNC_BYTES = 4,
    parameter int SYNC_W     = SYNC_BYTES * 8,
    parameter int SEL_W      = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              bit_valid,
    input  logic              bit_data,
    input  logic [SYNC_W-1:0] sync_word,
    input  logic [SEL_W-1:0]  sync_sel,
    output logic              match
);
    localparam int CW = $clog2(SYNC_W + 1) + 1;

    logic [SYNC_W-1:0] window;
    logic [SYNC_W-1:0] win_next;
    logic [SYNC_W-1:0] mask;
    logic [CW-1:0]     seen;
    logic [CW-1:0]     seen_p1;
    logic [CW-1:0]     nbits;

    // Derive the window that includes this bit and the compare mask.
    always_comb begin
        win_next = {window[SYNC_W-2:0], bit_data};
        nbits    = CW'((32'(sync_sel) + 32'd1) * 32'd8);
        mask     = ~({SYNC_W{1'b1}} << nbits);
        seen_p1  = seen + 1'b1;
        match    = en && bit_valid && (seen_p1 >= nbits)
                   && (((win_next ^ sync_word) & mask) == '0);
    end

    // Shift the window and count bits seen since searching began.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            window <= '0;
            seen   <= '0;
        end else if (!en) begin
            seen   <= '0;
        end else if (bit_valid) begin
            window <= win_next;
            if (seen != CW'(SYNC_W)) seen <= seen_p1;
        end
    end

    // R1: a match is never reported before enough bits were gathered.
    a_r1_enough_bits: assert property (@(posedge clk) disable iff (!rst_n)
        match |-> (seen + 1'b1 >= CW'(8)));

endmodule

// File: rtl/rxf_byte_asm.sv
// Byte assembler: packs eight bit strobes into one byte, MSB first.
// Does: emits a one-cycle strobe the cycle after the eighth bit.
// Assumes: the bit count restarts whenever en is low.
module rxf_byte_asm (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       bit_valid,
    input  logic       bit_data,
    output logic       byte_stb,
    output logic [7:0] byte_data
);
    logic [2:0] cnt;
    logic [6:0] sh;

    // Gather bits and release each full byte with a strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt       <= '0;
            sh        <= '0;
            byte_stb  <= 1'b0;
            byte_data <= '0;
        end else begin
            byte_stb <= 1'b0;
            if (!en) begin
                cnt <= '0;
            end else if (bit_valid) begin
                sh  <= {sh[5:0], bit_data};
                cnt <= cnt + 3'd1;
                if (cnt == 3'd7) begin
                    byte_stb  <= 1'b1;
                    byte_data <= {sh, bit_data};
                end
            end
        end
    end

    // R2: every byte strobe follows an accepted bit strobe.
    a_r2_byte_follows_bit: assert property (@(posedge clk) disable iff (!rst_n)
        byte_stb |-> $past(bit_valid && en));

endmodule

// File: rtl/rxf_hold_buf.sv
// Hold buffer for discard mode.
// Does: stores the bytes of one packet and, on release, plays them out one
// per cycle; a flush forgets everything stored.
// Assumes: no push arrives while draining; DEPTH covers the largest packet.
module rxf_hold_buf #(
    parameter int DEPTH = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push,
    input  logic [7:0] wdata,
    input  logic       flush,
    input  logic       release_go,
    output logic       rd_valid,
    output logic [7:0] rd_data
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int PW = $clog2(DEPTH + 1);

    logic [7:0]    mem [DEPTH];
    logic [PW-1:0] cnt;
    logic [PW-1:0] rd;
    logic          draining;

    // Write the incoming byte at the fill position.
    always_ff @(posedge clk) begin
        if (push) mem[cnt[AW-1:0]] <= wdata;
    end

    // Track fill level and the playback pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            rd       <= '0;
            draining <= 1'b0;
        end else if (flush) begin
            cnt      <= '0;
            rd       <= '0;
            draining <= 1'b0;
        end else if (release_go) begin
            rd       <= '0;
            draining <= (cnt != '0);
        end else if (draining) begin
            rd <= rd + 1'b1;
            if (rd + 1'b1 == cnt) begin
                draining <= 1'b0;
                cnt      <= '0;
                rd       <= '0;
            end
        end else if (push) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign rd_valid = draining;
    assign rd_data  = mem[rd[AW-1:0]];

    // R9: the buffer never overflows.
    a_r9_room_on_push: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (cnt < PW'(DEPTH)));
    // R9: playback and filling never overlap.
    a_r9_no_push_in_drain: assert property (@(posedge clk) disable iff (!rst_n)
        draining |-> !push);

endmodule

// File: rtl/rxpkt_framer.sv
// Receive packet framer (top).
// Does: searches for the start pattern, walks the address, length, payload
// and check-word fields, filters on address, checks the CRC and writes the
// surviving bytes to a FIFO write port, directly or through a hold buffer.
// Assumes: bit strobes at least two cycles apart; static configuration
// during a packet; cfg_fixed_len <= MAX_LEN.
module rxpkt_framer #(
    parameter int SYNC_BYTES = 4,
    parameter int MAX_LEN    = 30,
    parameter int SYNC_W     = SYNC_BYTES * 8,
    parameter int SEL_W      = (SYNC_BYTES > 1) ? $clog2(SYNC_BYTES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_valid,
    input  logic              bit_data,
    input  logic [SYNC_W-1:0] cfg_sync_word,
    input  logic [SEL_W-1:0]  cfg_sync_sel,
    input  logic              cfg_addr_en,
    input  logic [1:0]        cfg_addr_mode,
    input  logic [7:0]        cfg_node_addr,
    input  logic              cfg_len_en,
    input  logic [7:0]        cfg_fixed_len,
    input  logic              cfg_discard,
    output logic              out_valid,
    output logic [7:0]        out_data,
    output logic              hit_pulse,
    output logic              crc_ok,
    output logic              crc_err
);
    import rxf_pkg::*;

    localparam int         DEPTH     = MAX_LEN + 2;
    localparam logic [7:0] MAX_LEN_B = 8'(MAX_LEN);

    rxf_state_e st;
    logic [7:0]  remain;
    logic [15:0] crc_q;
    logic [7:0]  crc_hi;

    logic       hunt_en, asm_en, match;
    logic       byte_stb;
    logic [7:0] byte_data;
    logic       addr_ok, len_ok, crc_good;
    logic       take, direct_v, buf_push, buf_flush, buf_release;
    logic       buf_v;
    logic [7:0] buf_d;

    // Pick the first field after the address (or after the pattern).
    function automatic rxf_state_e first_body(input logic len_on,
                                              input logic [7:0] fixed);
        if (len_on)           return ST_LEN;
        else if (fixed == '0) return ST_CRC_HI;
        else                  return ST_PAY;
    endfunction

    assign hunt_en = (st == ST_HUNT);
    assign asm_en  = (st != ST_HUNT) && (st != ST_DRAIN);

    rxf_sync_hunt #(
        .SYNC_BYTES (SYNC_BYTES),
        .SYNC_W     (SYNC_W),
        .SEL_W      (SEL_W)
    ) u_hunt (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (hunt_en),
        .bit_valid (bit_valid),
        .bit_data  (bit_data),
        .sync_word (cfg_sync_word),
        .sync_sel  (cfg_sync_sel),
        .match     (match)
    );

    rxf_byte_asm u_asm (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (asm_en),
        .bit_valid (bit_valid),
        .bit_data  (bit_data),
        .byte_stb  (byte_stb),
        .byte_data (byte_data)
    );

    // Decide, for the byte just assembled, filter, length and CRC verdicts.
    always_comb begin
        addr_ok  = (byte_data == cfg_node_addr)
                || ((cfg_addr_mode != 2'b00) && (byte_data == 8'h00))
                || (cfg_addr_mode[1] && (byte_data == 8'hFF));
        len_ok   = (byte_data <= MAX_LEN_B);
        crc_good = ({crc_hi, byte_data} == crc_q);
        take     = byte_stb && (((st == ST_ADDR) && addr_ok)
                             || ((st == ST_LEN) && len_ok)
                             ||  (st == ST_PAY));
        direct_v    = take && !cfg_discard;
        buf_push    = take && cfg_discard;
        buf_flush   = byte_stb && (((st == ST_ADDR) && !addr_ok)
                                || ((st == ST_LEN) && !len_ok)
                                || ((st == ST_CRC_LO) && !crc_good));
        buf_release = byte_stb && (st == ST_CRC_LO) && crc_good && cfg_discard;
    end

    rxf_hold_buf #(
        .DEPTH (DEPTH)
    ) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (buf_push),
        .wdata      (byte_data),
        .flush      (buf_flush),
        .release_go (buf_release),
        .rd_valid   (buf_v),
        .rd_data    (buf_d)
    );

    // Walk the packet fields and run the CRC over accepted bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_HUNT;
            remain <= '0;
            crc_q  <= CRC_SEED;
            crc_hi <= '0;
        end else begin
            if (take) crc_q <= rxf_crc16_byte(crc_q, byte_data);
            unique case (st)
                ST_HUNT: if (match) begin
                    st     <= cfg_addr_en ? ST_ADDR : first_body(cfg_len_en, cfg_fixed_len);
                    remain <= cfg_fixed_len;
                    crc_q  <= CRC_SEED;
                end
                ST_ADDR: if (byte_stb) begin
                    st <= addr_ok ? first_body(cfg_len_en, cfg_fixed_len) : ST_HUNT;
                end
                ST_LEN: if (byte_stb) begin
                    remain <= byte_data;
                    if (!len_ok)                st <= ST_HUNT;
                    else if (byte_data == '0)   st <= ST_CRC_HI;
                    else                        st <= ST_PAY;
                end
                ST_PAY: if (byte_stb) begin
                    remain <= remain - 8'd1;
                    if (remain == 8'd1) st <= ST_CRC_HI;
                end
                ST_CRC_HI: if (byte_stb) begin
                    crc_hi <= byte_data;
                    st     <= ST_CRC_LO;
                end
                ST_CRC_LO: if (byte_stb) begin
                    st <= (crc_good && cfg_discard) ? ST_DRAIN : ST_HUNT;
                end
                ST_DRAIN: if (!buf_v) st <= ST_HUNT;
                default: st <= ST_HUNT;
            endcase
        end
    end

    // Register the FIFO write port and the event pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            hit_pulse <= 1'b0;
            crc_ok    <= 1'b0;
            crc_err   <= 1'b0;
        end else begin
            out_valid <= direct_v || buf_v;
            out_data  <= direct_v ? byte_data : buf_d;
            hit_pulse <= (match && !cfg_addr_en)
                      || (byte_stb && (st == ST_ADDR) && addr_ok);
            crc_ok    <= byte_stb && (st == ST_CRC_LO) && crc_good;
            crc_err   <= byte_stb && (st == ST_CRC_LO) && !crc_good;
        end
    end

    // R7: a packet gets one verdict, never both.
    a_r7_one_verdict: assert property (@(posedge clk) disable iff (!rst_n)
        !(crc_ok && crc_err));
    // R9: in discard mode bytes leave only during playback.
    a_r9_hold_until_good: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_discard && out_valid) |-> ($past(st) == ST_DRAIN));
    // R5: a rejected address returns to pattern search.
    a_r5_reject_to_hunt: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_stb && (st == ST_ADDR) && !addr_ok) |=> ((st == ST_HUNT) && !hit_pulse));
    // R10: an oversize length byte ends the packet with no output.
    a_r10_long_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_stb && (st == ST_LEN) && (byte_data > MAX_LEN_B)) |=> ((st == ST_HUNT) && !out_valid));

endmodule

// File: tb/tb_rxpkt_framer.sv
// Self-checking bench: a vector table of packet shapes, then directed cases.
module tb_rxpkt_framer;

    localparam logic [31:0] SYNC = 32'hC3A596F0;
    localparam logic [7:0]  NODE = 8'h5A;
    localparam int          NV   = 13;
    localparam int          MAXL = 30;

    // {mode[1:0], aen, len_en, disc, bad, sb[1:0], addr[7:0], plen[7:0]}
    localparam logic [23:0] VEC [NV] = '{
        {2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 2'd3, 8'h5A, 8'd4},
        {2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 2'd3, 8'h00, 8'd4},
        {2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 2'd3, 8'h00, 8'd3},
        {2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 2'd3, 8'hFF, 8'd3},
        {2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 2'd3, 8'hFF, 8'd2},
        {2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 2'd3, 8'h00, 8'd2},
        {2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 8'h00, 8'd3},
        {2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd1, 8'h00, 8'd5},
        {2'd0, 1'b1, 1'b1, 1'b0, 1'b1, 2'd3, 8'h5A, 8'd4},
        {2'd0, 1'b1, 1'b1, 1'b1, 1'b1, 2'd3, 8'h5A, 8'd4},
        {2'd0, 1'b1, 1'b1, 1'b1, 1'b0, 2'd3, 8'h5A, 8'd4},
        {2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 2'd2, 8'h5A, 8'd0},
        {2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 2'd3, 8'h5B, 8'd2}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_valid = 1'b0;
    logic        bit_data = 1'b0;
    logic [1:0]  cfg_sync_sel = 2'd3;
    logic        cfg_addr_en = 1'b0;
    logic [1:0]  cfg_addr_mode = 2'd0;
    logic        cfg_len_en = 1'b0;
    logic [7:0]  cfg_fixed_len = 8'd0;
    logic        cfg_discard = 1'b0;
    logic        out_valid, hit_pulse, crc_ok, crc_err;
    logic [7:0]  out_data;

    int errors = 0;
    int checks = 0;
    int n_hit = 0, n_ok = 0, n_err = 0;
    logic [7:0] got_q[$];
    logic [7:0] exp_q[$];

    always #2 clk = ~clk;

    rxpkt_framer dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .bit_valid     (bit_valid),
        .bit_data      (bit_data),
        .cfg_sync_word (SYNC),
        .cfg_sync_sel  (cfg_sync_sel),
        .cfg_addr_en   (cfg_addr_en),
        .cfg_addr_mode (cfg_addr_mode),
        .cfg_node_addr (NODE),
        .cfg_len_en    (cfg_len_en),
        .cfg_fixed_len (cfg_fixed_len),
        .cfg_discard   (cfg_discard),
        .out_valid     (out_valid),
        .out_data      (out_data),
        .hit_pulse     (hit_pulse),
        .crc_ok        (crc_ok),
        .crc_err       (crc_err)
    );

    // Collect output bytes and pulses away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid) got_q.push_back(out_data);
            if (hit_pulse) n_hit++;
            if (crc_ok)    n_ok++;
            if (crc_err)   n_err++;
        end
    end

    function automatic logic [15:0] ref_crc(input logic [15:0] c_in, input logic [7:0] d);
        logic [15:0] c;
        c = c_in ^ {d, 8'h00};
        for (int k = 0; k < 8; k++) c = c[15] ? ((c << 1) ^ 16'h1021) : (c << 1);
        return c;
    endfunction

    function automatic bit addr_pass(input logic [1:0] mode, input logic [7:0] a);
        return (a == NODE) || ((mode != 2'd0) && (a == 8'h00)) || (mode[1] && (a == 8'hFF));
    endfunction

    task automatic check(input bit cond, input string tag, input int act, input int exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic check_bytes(input string tag);
        int bad_at;
        bad_at = -1;
        if (got_q.size() != exp_q.size()) begin
            check(1'b0, {tag, " byte count"}, got_q.size(), exp_q.size());
        end else begin
            for (int i = 0; i < exp_q.size(); i++)
                if (bad_at < 0 && got_q[i] != exp_q[i]) bad_at = i;
            if (bad_at < 0) check(1'b1, tag, 0, 0);
            else check(1'b0, {tag, " byte value"}, got_q[bad_at], exp_q[bad_at]);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        bit_valid = 1'b0;
        repeat (3) @(negedge clk);
        got_q.delete();
        exp_q.delete();
        n_hit = 0; n_ok = 0; n_err = 0;
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        bit_valid = 1'b1;
        bit_data  = b;
        @(negedge clk);
        bit_valid = 1'b0;
        repeat (7) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
    endtask

    // Preamble, pattern, fields and check word; deliver adds bytes to exp_q.
    task automatic send_packet(input logic aen, input logic len_en, input logic [7:0] addr,
                               input logic [7:0] plen, input logic bad, input logic [1:0] sb,
                               input logic bad_sync, input logic deliver);
        logic [15:0] c;
        logic [7:0]  b;
        send_byte(8'hAA);
        send_byte(8'hAA);
        for (int k = int'(sb); k >= 0; k--) begin
            b = SYNC[k*8 +: 8];
            if (bad_sync && k == 0) b = b ^ 8'h01;
            send_byte(b);
        end
        c = 16'hFFFF;
        if (aen) begin
            send_byte(addr); c = ref_crc(c, addr);
            if (deliver) exp_q.push_back(addr);
        end
        if (len_en) begin
            send_byte(plen); c = ref_crc(c, plen);
            if (deliver) exp_q.push_back(plen);
        end
        for (int i = 0; i < int'(plen); i++) begin
            b = 8'h30 + 8'(i);
            send_byte(b); c = ref_crc(c, b);
            if (deliver) exp_q.push_back(b);
        end
        if (bad) c = c ^ 16'h0001;
        send_byte(c[15:8]);
        send_byte(c[7:0]);
        repeat (80) @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R11: reset state.
        do_reset();
        check(out_valid == 1'b0, "R11 out_valid after reset", out_valid, 0);
        check((hit_pulse | crc_ok | crc_err) == 1'b0, "R11 pulses after reset",
              hit_pulse | crc_ok | crc_err, 0);

        // R1: noise that never forms the pattern gives nothing.
        cfg_addr_en = 1'b1; cfg_len_en = 1'b1; cfg_sync_sel = 2'd3;
        send_byte(8'h55); send_byte(8'h3C); send_byte(8'h0F); send_byte(8'hC3);
        repeat (20) @(negedge clk);
        check(got_q.size() == 0 && n_hit == 0, "R1 noise ignored", got_q.size() + n_hit, 0);

        // R1: pattern with one wrong bit gives nothing.
        do_reset();
        send_packet(1'b1, 1'b1, NODE, 8'd3, 1'b0, 2'd3, 1'b1, 1'b0);
        check(got_q.size() == 0 && n_hit == 0 && n_ok == 0, "R1 one-bit pattern error",
              got_q.size() + n_hit + n_ok, 0);

        // Table of packet shapes: R2 R3 R4 R5 R6 R7 R8 R9.
        for (int v = 0; v < NV; v++) begin
            logic [1:0] mode, sb;
            logic aen, len_en, disc, bad, pass;
            logic [7:0] addr, plen;
            {mode, aen, len_en, disc, bad, sb, addr, plen} = VEC[v];
            pass = !aen || addr_pass(mode, addr);
            cfg_addr_mode = mode; cfg_addr_en = aen; cfg_len_en = len_en;
            cfg_discard = disc; cfg_sync_sel = sb; cfg_fixed_len = plen;
            do_reset();
            send_packet(aen, len_en, addr, plen, bad, sb, 1'b0, pass && !(bad && disc));
            check_bytes($sformatf("R2 R3 R4 R5 R8 R9 vec%0d bytes", v));
            check(n_hit == int'(pass), $sformatf("R6 R5 vec%0d hit", v), n_hit, int'(pass));
            check(n_ok == int'(pass && !bad), $sformatf("R7 vec%0d crc_ok", v),
                  n_ok, int'(pass && !bad));
            check(n_err == int'(pass && bad), $sformatf("R7 R8 R9 vec%0d crc_err", v),
                  n_err, int'(pass && bad));
        end

        // R10: length byte one above the limit is dropped.
        cfg_addr_en = 1'b0; cfg_len_en = 1'b1; cfg_discard = 1'b0; cfg_sync_sel = 2'd3;
        do_reset();
        send_packet(1'b0, 1'b1, 8'h00, 8'(MAXL + 1), 1'b0, 2'd3, 1'b0, 1'b0);
        check(got_q.size() == 0, "R10 oversize length no bytes", got_q.size(), 0);
        check(n_ok + n_err == 0, "R10 oversize length no verdict", n_ok + n_err, 0);

        // R9: largest packet fills the hold buffer exactly.
        cfg_addr_en = 1'b1; cfg_addr_mode = 2'd0; cfg_discard = 1'b1;
        do_reset();
        send_packet(1'b1, 1'b1, NODE, 8'(MAXL), 1'b0, 2'd3, 1'b0, 1'b1);
        check_bytes("R9 R10 full-size held packet");
        check(n_ok == 1, "R9 full-size crc_ok", n_ok, 1);

        // R12: two packets back to back without reset.
        cfg_discard = 1'b0;
        do_reset();
        send_packet(1'b1, 1'b1, NODE, 8'd2, 1'b0, 2'd3, 1'b0, 1'b1);
        send_packet(1'b1, 1'b1, NODE, 8'd3, 1'b0, 2'd3, 1'b0, 1'b1);
        check_bytes("R12 second packet bytes");
        check(n_ok == 2, "R12 two verdicts", n_ok, 2);
        check(n_hit == 2, "R12 two hits", n_hit, 2);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule